// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block drives a two-wire I2C bus as a master that only writes. The host sets a 7-bit target address and an SCL waveform, then sets the enable bit. The waveform has separate high and low counts and a shared power-of-two prescaler. The first byte put into the holding register starts a frame. The block sends a START condition, then the address with a zero direction bit, then the held byte. Each later byte follows in the same way, and every byte is followed by an acknowledge slot.

Between bytes the master keeps SCL low for as long as no new byte is waiting and no stop has been requested. A ready flag shows that the holding register has been emptied. A sticky flag records a refused byte. Each flag can drive the interrupt line when its enable is set. Both bus wires are open-drain. The outputs are pull-low enables, and the bench or the pads resolve the actual line levels.

Top module: `i2c_wr_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are sclOe=0, sdaOe=0, txRdy=0, nackFlag=0 and irq=0.
- R2: In idle with masterEn=1, a byte write starts a frame. SDA falls while SCL is high (START). The first byte on the bus is {slaveAddr[6:0], 1'b0}, MSB first, with bit 0 being the direction bit, 0 for write.
- R3: In every bit, SCL is released for exactly highCnt·2^clkExp+4 cycles. When the next bit is already known, SCL is pulled low for exactly lowCnt·2^clkExp+4 cycles.
- R4: Within a frame, SDA changes only while SCL is low. The only SDA edges seen while SCL is high are the one START and the one STOP.
- R5: Data bytes go out MSB first, in the order they were written. A byte moves from the holding register into the shifter when the previous byte is acknowledged.
- R6: txRdy rises when a byte is acknowledged (the ninth-bit sample of sdaIn is 0). It falls in the cycle after the next accepted write.
- R7: After an acknowledged byte, if no byte is waiting and no stop is pending, SCL stays pulled low. A later write releases it and transmission resumes.
- R8: A stopReq pulse during a frame makes the master end the frame with STOP after the current byte's acknowledge, once no byte is waiting. From the stretched state it ends the frame at once. The bus is then released on both wires.
- R9: A ninth-bit sample of 1 sets nackFlag, which stays set until a nackClr pulse. The master then sends STOP on its own, discards any waiting byte, clears txRdy and starts no new frame.
- R10: irq = (nackFlag and nackIntEn) or (txRdy and txRdyIntEn).
- R11: While masterEn=0, thrWrite is ignored: no frame starts, and nothing is left over to start one when masterEn is later set.
- R12: slaveAddr is captured at START. Changing it during a frame affects only the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterEn | input | 1 | Master enable; writes are accepted only while high |
| slaveAddr | input | 7 | Target address, captured at START |
| clkExp | input | EXP_W (3) | Prescaler exponent for SCL phases |
| highCnt | input | DIV_W (8) | SCL high-phase count |
| lowCnt | input | DIV_W (8) | SCL low-phase count |
| thrWrite | input | 1 | One-cycle write strobe for the holding register |
| thrData | input | 8 | Byte to transmit |
| stopReq | input | 1 | One-cycle request to end the frame with STOP |
| nackClr | input | 1 | One-cycle clear of nackFlag |
| nackIntEn | input | 1 | Interrupt enable for nackFlag |
| txRdyIntEn | input | 1 | Interrupt enable for txRdy |
| sdaIn | input | 1 | Resolved SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| txRdy | output | 1 | Holding register emptied by an acknowledge |
| nackFlag | output | 1 | Sticky not-acknowledge status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on three assumptions about the bus and the host:
- No other device holds SCL low.
- The target pulls SDA low only during the acknowledge slot.
- stopReq, nackClr and thrWrite arrive as single-cycle pulses, while the waveform settings change only when the bus is idle.

The bench's target model keeps to these rules. It drives the acknowledge on the SCL falling edge after the eighth bit and releases it on the next falling edge. The host side of the stimulus changes the prescaler and the counts only between frames, after STOP has been seen. The slave address is the only setting it changes in mid-frame, and it does so on purpose.

// File: rtl/i2cwm_pkg.sv
package i2cwm_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT_LOW, S_BIT_HIGH, S_HOLD, S_STOP_LOW, S_STOP_HIGH, S_FREE
  } phase_e;

  typedef enum logic [1:0] {SDA_REL, SDA_LOW, SDA_DATA} sdaMode_e;

  typedef struct packed {
    logic     loadLow;
    logic     loadHigh;
    logic     loadAddr;
    logic     moveHold;
    logic     dropHold;
    logic     shiftBit;
    sdaMode_e sdaMode;
  } dpStrobe_t;
endpackage

// File: rtl/i2cwm_datapath.sv
module i2cwm_datapath import i2cwm_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              wrAccept,
  input  logic [BYTE_W-1:0] thrData,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic [EXP_W-1:0]  clkExp,
  input  logic [DIV_W-1:0]  highCnt,
  input  logic [DIV_W-1:0]  lowCnt,
  output logic              timerDone,
  output logic              lastBit,
  output logic              holdFull,
  output logic              sdaOe
);
  localparam int TMR_W = DIV_W + (1 << EXP_W) + 1;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [TMR_W-1:0]  lowSpan, highSpan, timerQ;
  logic [BYTE_W-1:0] holdQ, shiftQ;
  logic [CNT_W-1:0]  bitCnt;

  // phase length = count scaled by prescaler plus fixed overhead
  assign lowSpan  = (TMR_W'(lowCnt)  << clkExp) + TMR_W'(4);
  assign highSpan = (TMR_W'(highCnt) << clkExp) + TMR_W'(4);

  always_ff @(posedge clk) begin
    if (!rstN)             timerQ <= '0;
    else if (stb.loadLow)  timerQ <= lowSpan - TMR_W'(1);
    else if (stb.loadHigh) timerQ <= highSpan - TMR_W'(1);
    else if (timerQ != '0) timerQ <= timerQ - TMR_W'(1);
  end
  assign timerDone = (timerQ == '0);

  // holding register: a new write wins over a move or a discard
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ    <= '0;
      holdFull <= 1'b0;
    end else if (wrAccept) begin
      holdQ    <= thrData;
      holdFull <= 1'b1;
    end else if (stb.moveHold || stb.dropHold) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      bitCnt <= '0;
    end else if (stb.loadAddr) begin
      shiftQ <= {slaveAddr, 1'b0};
      bitCnt <= '0;
    end else if (stb.moveHold) begin
      shiftQ <= holdQ;
      bitCnt <= '0;
    end else if (stb.shiftBit) begin
      shiftQ <= {shiftQ[BYTE_W-2:0], 1'b0};
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end
  assign lastBit = (bitCnt == CNT_W'(BYTE_W));

  // registered one cycle behind the phase so SDA moves after SCL falls
  always_ff @(posedge clk) begin
    if (!rstN) sdaOe <= 1'b0;
    else begin
      case (stb.sdaMode)
        SDA_LOW:  sdaOe <= 1'b1;
        SDA_DATA: sdaOe <= !lastBit && !shiftQ[BYTE_W-1];
        default:  sdaOe <= 1'b0;
      endcase
    end
  end

  a_r2_dir_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadAddr |=> (shiftQ[0] == 1'b0));
  a_r5_move_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    stb.moveHold |-> holdFull);
endmodule

// File: rtl/i2cwm_ctrl.sv
module i2cwm_ctrl import i2cwm_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      masterEn,
  input  logic      wrAccept,
  input  logic      stopReq,
  input  logic      nackClr,
  input  logic      sdaIn,
  input  logic      timerDone,
  input  logic      lastBit,
  input  logic      holdFull,
  output dpStrobe_t stb,
  output logic      sclOe,
  output logic      txRdy,
  output logic      nackFlag,
  output phase_e    phase
);
  phase_e stateQ, stateD;
  logic   stopPendQ, ackEv, nackEv, inFrame;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    ackEv  = 1'b0;
    nackEv = 1'b0;
    case (stateQ)
      S_IDLE: if (masterEn && holdFull) begin
        stateD = S_START; stb.loadHigh = 1'b1; stb.loadAddr = 1'b1;
      end
      S_START: if (timerDone) begin
        stateD = S_BIT_LOW; stb.loadLow = 1'b1;
      end
      S_BIT_LOW: if (timerDone) begin
        stateD = S_BIT_HIGH; stb.loadHigh = 1'b1;
      end
      S_BIT_HIGH: if (timerDone) begin
        if (!lastBit) begin
          stateD = S_BIT_LOW; stb.loadLow = 1'b1; stb.shiftBit = 1'b1;
        end else if (sdaIn) begin
          nackEv = 1'b1; stb.dropHold = 1'b1;
          stateD = S_STOP_LOW; stb.loadLow = 1'b1;
        end else begin
          ackEv = 1'b1;
          if (holdFull) begin
            stateD = S_BIT_LOW; stb.loadLow = 1'b1; stb.moveHold = 1'b1;
          end else if (stopPendQ) begin
            stateD = S_STOP_LOW; stb.loadLow = 1'b1;
          end else begin
            stateD = S_HOLD;
          end
        end
      end
      S_HOLD: begin
        if (holdFull) begin
          stateD = S_BIT_LOW; stb.loadLow = 1'b1; stb.moveHold = 1'b1;
        end else if (stopPendQ) begin
          stateD = S_STOP_LOW; stb.loadLow = 1'b1;
        end
      end
      S_STOP_LOW: if (timerDone) begin
        stateD = S_STOP_HIGH; stb.loadHigh = 1'b1;
      end
      S_STOP_HIGH: if (timerDone) begin
        stateD = S_FREE; stb.loadHigh = 1'b1;
      end
      S_FREE: if (timerDone) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase

    case (stateQ)
      S_START, S_STOP_LOW, S_STOP_HIGH: stb.sdaMode = SDA_LOW;
      S_BIT_LOW, S_BIT_HIGH:            stb.sdaMode = SDA_DATA;
      default:                          stb.sdaMode = SDA_REL;
    endcase
  end

  assign sclOe   = (stateQ == S_BIT_LOW) || (stateQ == S_HOLD) || (stateQ == S_STOP_LOW);
  assign phase   = stateQ;
  assign inFrame = (stateQ == S_START) || (stateQ == S_BIT_LOW) ||
                   (stateQ == S_BIT_HIGH) || (stateQ == S_HOLD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      stopPendQ <= 1'b0;
      txRdy     <= 1'b0;
      nackFlag  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateD == S_STOP_LOW && stateQ != S_STOP_LOW) stopPendQ <= 1'b0;
      else if (stopReq && inFrame)                      stopPendQ <= 1'b1;
      if (nackEv)        txRdy <= 1'b0;
      else if (wrAccept) txRdy <= 1'b0;
      else if (ackEv)    txRdy <= 1'b1;
      if (nackEv)       nackFlag <= 1'b1;
      else if (nackClr) nackFlag <= 1'b0;
    end
  end

  a_r6_write_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |=> !txRdy);
  a_r9_nack_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (nackFlag && !nackClr) |=> nackFlag);
  a_r8_stop_from_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_HOLD && stopPendQ && !holdFull) |=> (stateQ == S_STOP_LOW));
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master import i2cwm_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEn,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic [EXP_W-1:0]  clkExp,
  input  logic [DIV_W-1:0]  highCnt,
  input  logic [DIV_W-1:0]  lowCnt,
  input  logic              thrWrite,
  input  logic [BYTE_W-1:0] thrData,
  input  logic              stopReq,
  input  logic              nackClr,
  input  logic              nackIntEn,
  input  logic              txRdyIntEn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              txRdy,
  output logic              nackFlag,
  output logic              irq
);
  dpStrobe_t stb;
  phase_e    phase;
  logic      wrAccept, timerDone, lastBit, holdFull;

  assign wrAccept = thrWrite && masterEn;

  i2cwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .wrAccept(wrAccept),
    .stopReq(stopReq), .nackClr(nackClr), .sdaIn(sdaIn),
    .timerDone(timerDone), .lastBit(lastBit), .holdFull(holdFull),
    .stb(stb), .sclOe(sclOe), .txRdy(txRdy), .nackFlag(nackFlag), .phase(phase)
  );

  i2cwm_datapath #(.DIV_W(DIV_W), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAccept(wrAccept), .thrData(thrData),
    .slaveAddr(slaveAddr), .clkExp(clkExp), .highCnt(highCnt), .lowCnt(lowCnt),
    .timerDone(timerDone), .lastBit(lastBit), .holdFull(holdFull), .sdaOe(sdaOe)
  );

  assign irq = (nackFlag && nackIntEn) || (txRdy && txRdyIntEn);

  a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (phase == S_BIT_HIGH && $past(phase) == S_BIT_HIGH) |-> $stable(sdaOe));
endmodule

// File: tb/i2c_wr_master_tb.sv
`timescale 1ns/100ps
module i2c_wr_master_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0, masterEn = 1'b0, thrWrite = 1'b0, stopReq = 1'b0, nackClr = 1'b0;
  logic       nackIntEn = 1'b0, txRdyIntEn = 1'b0;
  logic [6:0] slaveAddr = '0;
  logic [2:0] clkExp = '0;
  logic [7:0] highCnt = '0, lowCnt = '0, thrData = '0;
  logic       sdaIn, sclOe, sdaOe, txRdy, nackFlag, irq;
  logic       ackDrive = 1'b0;

  assign sdaIn = !(sdaOe || ackDrive);

  i2c_wr_master u_dut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .slaveAddr(slaveAddr),
    .clkExp(clkExp), .highCnt(highCnt), .lowCnt(lowCnt), .thrWrite(thrWrite),
    .thrData(thrData), .stopReq(stopReq), .nackClr(nackClr), .nackIntEn(nackIntEn),
    .txRdyIntEn(txRdyIntEn), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe),
    .txRdy(txRdy), .nackFlag(nackFlag), .irq(irq)
  );

  // target model and bus monitor, evaluated on the falling clock edge
  int   startCnt, stopCnt, byteNo, bitNo, rxCnt, cyc, lastChange;
  int   highExact, highBad, lowExact, nackAt = -1, expLow = 4, expHigh = 4;
  logic ackPhase, skipFall, prevScl, prevSda, sclNow, sdaNow, clrStats = 1'b0;
  logic [7:0] sh;
  logic [7:0] rxBuf [0:7];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rstN || clrStats) begin
      startCnt = 0; stopCnt = 0; byteNo = 0; bitNo = 0; rxCnt = 0;
      highExact = 0; highBad = 0; lowExact = 0; ackPhase = 1'b0; skipFall = 1'b0;
      if (!rstN) begin
        ackDrive = 1'b0; prevScl = 1'b1; prevSda = 1'b1; lastChange = cyc;
      end
    end else begin
      sclNow = !sclOe;
      sdaNow = sdaIn;
      if (prevScl && sclNow && prevSda && !sdaNow) begin
        startCnt = startCnt + 1; bitNo = 0; byteNo = 0; ackPhase = 1'b0; skipFall = 1'b1;
      end else if (prevScl && sclNow && !prevSda && sdaNow) begin
        stopCnt = stopCnt + 1; ackDrive = 1'b0;
      end
      if (!prevScl && sclNow) begin
        if (cyc - lastChange == expLow) lowExact = lowExact + 1;
        if (bitNo < 8 && !ackPhase) begin
          sh = {sh[6:0], sdaNow}; bitNo = bitNo + 1;
        end
        lastChange = cyc;
      end else if (prevScl && !sclNow) begin
        if (skipFall) skipFall = 1'b0;
        else if (cyc - lastChange == expHigh) highExact = highExact + 1;
        else highBad = highBad + 1;
        if (ackPhase) begin
          ackDrive = 1'b0; ackPhase = 1'b0; bitNo = 0; byteNo = byteNo + 1;
        end else if (bitNo == 8) begin
          if (rxCnt < 8) rxBuf[rxCnt] = sh;
          rxCnt = rxCnt + 1;
          ackDrive = (byteNo != nackAt);
          ackPhase = 1'b1;
        end
        lastChange = cyc;
      end
      prevScl = sclNow;
      prevSda = sdaNow;
    end
  end

  int total = 0, bad = 0, wdog = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic writeByte(input logic [7:0] d);
    thrData = d; thrWrite = 1'b1; tick(); thrWrite = 1'b0;
  endtask

  task automatic pulseStop();
    stopReq = 1'b1; tick(); stopReq = 1'b0;
  endtask

  task automatic clearStats();
    clrStats = 1'b1; tick(); clrStats = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 20000 && !txRdy; i++) tick();
  endtask

  task automatic waitByteNo(input int n);
    for (int i = 0; i < 20000 && byteNo < n; i++) tick();
  endtask

  task automatic waitStop(input int n);
    for (int i = 0; i < 20000 && stopCnt < n; i++) tick();
    waitN(expHigh + 10);
  endtask

  initial begin
    for (int i = 0; i < 190000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitN(4);
    // R1 reset state
    chk(sclOe == 0 && sdaOe == 0, "R1 bus released in reset", {sclOe, sdaOe}, 0);
    chk(txRdy == 0 && nackFlag == 0 && irq == 0, "R1 flags clear", {txRdy, nackFlag, irq}, 0);
    rstN = 1'b1;
    tick();
    chk(sclOe == 0 && sdaOe == 0 && txRdy == 0 && irq == 0, "R1 after reset",
        {sclOe, sdaOe, txRdy, irq}, 0);

    // R11 writes ignored while disabled
    writeByte(8'h5A);
    waitN(100);
    chk(startCnt == 0 && sclOe == 0 && sdaOe == 0, "R11 no frame while disabled", startCnt, 0);
    chk(txRdy == 0, "R11 ready untouched", txRdy, 0);
    masterEn = 1'b1;
    waitN(60);
    chk(startCnt == 0, "R11 nothing left after enable", startCnt, 0);

    // sweep over waveform settings, streaming then stretched transfers
    for (int e = 0; e < 3; e++) begin
      for (int li = 0; li < 3; li++) begin
        for (int hi = 0; hi < 2; hi++) begin
          automatic int cfg = e * 6 + li * 2 + hi;
          automatic logic [6:0] addr = 7'((cfg * 13 + 5) & 127);
          automatic logic [7:0] d0 = 8'((cfg * 37 + 1) & 255);
          automatic logic [7:0] d1 = 8'((cfg * 53 + 7) & 255);
          automatic logic [7:0] d2 = 8'((cfg * 91 + 200) & 255);
          clkExp = 3'(e); lowCnt = 8'(li * (li + 1)); highCnt = 8'(hi * 3);
          expLow  = ((li * (li + 1)) << e) + 4;
          expHigh = ((hi * 3) << e) + 4;
          slaveAddr = addr; nackAt = -1;
          clearStats();
          writeByte(d0);
          waitReady();
          writeByte(d1);
          waitByteNo(3);
          waitN(3 * (expLow + expHigh));
          chk(sclOe == 1, "R7 SCL stretched with nothing queued", sclOe, 1);
          chk(txRdy == 1 && stopCnt == 0, "R6 ready set while stretched", txRdy, 1);
          writeByte(d2);
          chk(txRdy == 0, "R6 write clears ready", txRdy, 0);
          waitByteNo(4);
          waitN(5);
          pulseStop();
          waitStop(1);
          chk(rxCnt == 4, "R5 byte count", rxCnt, 4);
          chk(rxBuf[0] == {addr, 1'b0}, "R2 address byte", rxBuf[0], {addr, 1'b0});
          chk(rxBuf[1] == d0 && rxBuf[2] == d1, "R5 data order", {rxBuf[1], rxBuf[2]}, {d0, d1});
          chk(rxBuf[3] == d2, "R7 resumed byte", rxBuf[3], d2);
          chk(startCnt == 1 && stopCnt == 1, "R4 single START and STOP", startCnt * 10 + stopCnt, 11);
          chk(highExact == 36 && highBad == 0, "R3 high phase length", highExact - highBad, 36);
          chk(lowExact == 35, "R3 low phase length", lowExact, 35);
          chk(sclOe == 0 && sdaOe == 0 && nackFlag == 0, "R8 bus released after STOP",
              {sclOe, sdaOe, nackFlag}, 0);
        end
      end
    end

    // R9 / R10 refused data byte
    clkExp = 3'd0; lowCnt = 8'd1; highCnt = 8'd1; expLow = 5; expHigh = 5;
    nackIntEn = 1'b1; nackAt = 1; slaveAddr = 7'h33;
    clearStats();
    writeByte(8'hC3);
    waitReady();
    writeByte(8'h3C);
    waitStop(1);
    waitN(60);
    chk(nackFlag == 1, "R9 nack flag set", nackFlag, 1);
    chk(irq == 1, "R10 irq on nack", irq, 1);
    chk(txRdy == 0, "R9 ready cleared", txRdy, 0);
    chk(rxCnt == 2 && startCnt == 1, "R9 auto stop, queued byte dropped", rxCnt * 10 + startCnt, 21);
    waitN(20);
    chk(nackFlag == 1, "R9 flag sticky", nackFlag, 1);
    nackClr = 1'b1; tick(); nackClr = 1'b0;
    chk(nackFlag == 0 && irq == 0, "R9 flag cleared", {nackFlag, irq}, 0);

    // R9 refused address
    nackAt = 0;
    clearStats();
    writeByte(8'h81);
    waitStop(1);
    chk(nackFlag == 1 && rxCnt == 1 && stopCnt == 1, "R9 address nack", rxCnt, 1);
    nackClr = 1'b1; tick(); nackClr = 1'b0;
    nackIntEn = 1'b0;

    // R8 pending stop, R12 address change mid-frame, R10 ready interrupt
    txRdyIntEn = 1'b1; nackAt = -1; slaveAddr = 7'h2A;
    clearStats();
    writeByte(8'h96);
    waitN(3);
    slaveAddr = 7'h55;
    pulseStop();
    waitStop(1);
    chk(rxBuf[0] == {7'h2A, 1'b0}, "R12 old address kept", rxBuf[0], {7'h2A, 1'b0});
    chk(rxCnt == 2 && rxBuf[1] == 8'h96 && stopCnt == 1, "R8 stop after pending request", rxCnt, 2);
    chk(txRdy == 1 && irq == 1, "R10 irq on ready", {txRdy, irq}, 3);
    clearStats();
    writeByte(8'h11);
    chk(irq == 0, "R10 irq drops with ready", irq, 0);
    waitReady();
    pulseStop();
    waitStop(1);
    chk(rxBuf[0] == {7'h55, 1'b0} && rxCnt == 2, "R12 new address used", rxBuf[0], {7'h55, 1'b0});

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule